// File: doc/BRIEF.md
# Level-Interrupt GPIO Port

This block is a general-purpose I/O port of `NPINS` pins (32 by default) with a small interrupt pending/mask unit next to it. Software reaches both through one single-cycle register bus: the top address bit picks one of two register windows. The port window holds the pin direction, the output data, a per-pin interrupt polarity and the interrupt status. The interrupt window holds a read-only pending view and a mask. Each pad is modelled as three separate signals: an input, an output value and an output enable.

Pin inputs pass through a two-stage synchroniser. A pin raises its status bit on every cycle in which its synchronised level equals its polarity bit, so only level-sensitive interrupts exist. Software acknowledges a pin by writing a word with that pin's bit at zero and all other bits at one. The single parent interrupt output is the registered OR of all pending bits whose mask bit is clear. A handler reads pending, drops the bits set in the mask, and services one pin for each remaining bit.

Top module: `gpio_lvl_irq_port`

## Requirements
- R1: After reset the mask reads all ones. Direction, output data, polarity and status read zero. `irq_out` is 0.
- R2: Bit 4 of `bus_addr` selects the window: 0 is the port window, 1 is the interrupt window. Port offset 0x00 is direction and offset 0x04 is output data. A direction bit of 1 drives `pin_oe` high for that pin. `pin_out` carries the data register.
- R3: `pin_in` passes through two flops. Reading port offset 0x04 returns the written data for pins whose direction bit is 1, and the synchronised level for pins whose direction bit is 0.
- R4: Port offset 0x08 holds the polarity. On any clock edge without an acknowledge write, a pin's status bit becomes 1 if its synchronised level equals its polarity bit (1 means high, 0 means low). Otherwise the bit holds its value.
- R5: A write to port offset 0x0C clears every status bit written as 0 and keeps every bit written as 1. The level test is not applied on that edge. If the level still matches, the bit sets again on the next edge.
- R6: Interrupt-window offset 0x00 reads the status vector. Writes to it are ignored.
- R7: Interrupt-window offset 0x08 is the mask and can be read and written. A mask bit of 1 blocks that pin from `irq_out`.
- R8: `irq_out` equals the OR of (status AND NOT mask) as it stood one clock edge earlier.
- R9: `bus_rdata` is zero when `bus_rd` is low or when the offset is unmapped. Unmapped offsets are non-multiples of 4, and 0x04 and 0x0C in the interrupt window. Writes to unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_addr | input | 5 | Bit 4 selects the window; bits 3:0 give the byte offset |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Read data |
| pin_in | input | NPINS | Pad input levels, asynchronous |
| pin_out | output | NPINS | Pad output values |
| pin_oe | output | NPINS | Pad output enables |
| irq_out | output | 1 | Parent interrupt, registered |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high together and that bus inputs stay constant around each rising edge. They also assume the window bit and offset are known whenever a strobe is high. The bench changes every bus and pin input on the falling edge, issues one operation per cycle, and drives both strobes low between operations. It moves pins asynchronously only relative to the synchroniser, and it expects the two-flop delay. It takes no timing from internal probes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int OFS_W = 4;

  typedef enum logic {
    WIN_PORT = 1'b0,
    WIN_IRQ  = 1'b1
  } win_e;

  localparam logic [OFS_W-1:0] OFS_DIR  = 4'h0;
  localparam logic [OFS_W-1:0] OFS_DATA = 4'h4;
  localparam logic [OFS_W-1:0] OFS_POL  = 4'h8;
  localparam logic [OFS_W-1:0] OFS_STAT = 4'hC;
  localparam logic [OFS_W-1:0] OFS_PEND = 4'h0;
  localparam logic [OFS_W-1:0] OFS_MASK = 4'h8;

  // level condition for one pin: pin level equals requested polarity
  function automatic logic level_match(input logic lvl, input logic pol);
    return ~(lvl ^ pol);
  endfunction

  // next status of one pin
  function automatic logic stat_next(input logic cur, input logic ack_we,
                                     input logic keep, input logic hit);
    return ack_we ? (cur & keep) : (cur | hit);
  endfunction

  // pin read-back: driven value for outputs, sampled level for inputs
  function automatic logic pin_view(input logic is_out, input logic drv,
                                    input logic lvl);
    return is_out ? drv : lvl;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_dir,
  input  logic         we_dout,
  input  logic         we_pol,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] dout_q,
  output logic [W-1:0] pol_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      dout_q <= '0;
      pol_q  <= '0;
    end else begin
      if (we_dir)  dir_q  <= wdata;
      if (we_dout) dout_q <= wdata;
      if (we_pol)  pol_q  <= wdata;
    end
  end
endmodule

// File: rtl/gpio_lvl_status.sv
module gpio_lvl_status #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl_sync,
  input  logic [W-1:0] pol_q,
  input  logic         ack_we,
  input  logic [W-1:0] ack_keep,
  output logic [W-1:0] hit,
  output logic [W-1:0] status_q
);
  import gpio_irq_pkg::*;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign hit[i] = level_match(lvl_sync[i], pol_q[i]);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q[i] <= 1'b0;
        else        status_q[i] <= stat_next(status_q[i], ack_we, ack_keep[i], hit[i]);
      end
    end
  endgenerate
endmodule

// File: rtl/gpio_pic_unit.sv
module gpio_pic_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_mask,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pend,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] live,
  output logic         irq_q
);
  assign live = pend & ~mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
      irq_q  <= 1'b0;
    end else begin
      if (we_mask) mask_q <= wdata;
      irq_q <= |live;
    end
  end
endmodule

// File: rtl/gpio_lvl_irq_port.sv
module gpio_lvl_irq_port #(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [4:0]       bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq_out
);
  import gpio_irq_pkg::*;

  localparam int ADDR_W = OFS_W + 1;

  win_e             win;
  logic [OFS_W-1:0] ofs;
  logic             in_port, in_irq;
  logic             ev_dir_we, ev_dout_we, ev_pol_we, ev_ack_we, ev_mask_we;
  logic [NPINS-1:0] lvl_sync, dir_q, dout_q, pol_q, status_q, mask_q;
  logic [NPINS-1:0] ev_hit, ev_live, data_view, rd_mux;
  logic             irq_q;

  assign win     = win_e'(bus_addr[ADDR_W-1]);
  assign ofs     = bus_addr[OFS_W-1:0];
  assign in_port = (win == WIN_PORT);
  assign in_irq  = (win == WIN_IRQ);

  assign ev_dir_we  = bus_wr && in_port && (ofs == OFS_DIR);
  assign ev_dout_we = bus_wr && in_port && (ofs == OFS_DATA);
  assign ev_pol_we  = bus_wr && in_port && (ofs == OFS_POL);
  assign ev_ack_we  = bus_wr && in_port && (ofs == OFS_STAT);
  assign ev_mask_we = bus_wr && in_irq  && (ofs == OFS_MASK);

  gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(pin_in), .d_sync(lvl_sync)
  );

  gpio_port_regs #(.W(NPINS)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we_dir(ev_dir_we), .we_dout(ev_dout_we), .we_pol(ev_pol_we),
    .wdata(bus_wdata),
    .dir_q(dir_q), .dout_q(dout_q), .pol_q(pol_q)
  );

  gpio_lvl_status #(.W(NPINS)) u_stat (
    .clk(clk), .rst_n(rst_n),
    .lvl_sync(lvl_sync), .pol_q(pol_q),
    .ack_we(ev_ack_we), .ack_keep(bus_wdata),
    .hit(ev_hit), .status_q(status_q)
  );

  gpio_pic_unit #(.W(NPINS)) u_pic (
    .clk(clk), .rst_n(rst_n),
    .we_mask(ev_mask_we), .wdata(bus_wdata), .pend(status_q),
    .mask_q(mask_q), .live(ev_live), .irq_q(irq_q)
  );

  genvar p;
  generate
    for (p = 0; p < NPINS; p++) begin : g_view
      assign data_view[p] = pin_view(dir_q[p], dout_q[p], lvl_sync[p]);
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    if (in_port) begin
      case (ofs)
        OFS_DIR:  rd_mux = dir_q;
        OFS_DATA: rd_mux = data_view;
        OFS_POL:  rd_mux = pol_q;
        OFS_STAT: rd_mux = status_q;
        default:  rd_mux = '0;
      endcase
    end else begin
      case (ofs)
        OFS_PEND: rd_mux = status_q;
        OFS_MASK: rd_mux = mask_q;
        default:  rd_mux = '0;
      endcase
    end
  end

  assign bus_rdata = bus_rd ? rd_mux : '0;
  assign pin_out   = dout_q;
  assign pin_oe    = dir_q;
  assign irq_out   = irq_q;
endmodule

// File: rtl/gpio_lvl_irq_chk.sv
module gpio_lvl_irq_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] bus_wdata,
  input logic [W-1:0] status_q,
  input logic [W-1:0] mask_q,
  input logic [W-1:0] ev_hit,
  input logic [W-1:0] pin_oe,
  input logic         ev_ack_we,
  input logic         ev_dir_we,
  input logic         irq_out
);
  // R1: state right after reset release
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask_q == '1 && status_q == '0 && !irq_out && pin_oe == '0));

  // R2: a direction write shows on the output enables
  a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
    ev_dir_we |=> (pin_oe == $past(bus_wdata)));

  // R4: a level match sets status when no acknowledge is written
  a_r4_level_sets: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_ack_we |=> ((status_q & $past(ev_hit)) == $past(ev_hit)));

  // R5: bits written as zero are clear after the acknowledge
  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ack_we |=> ((status_q & ~$past(bus_wdata)) == '0));

  // R7: with every source masked the parent line stays low
  a_r7_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |=> !irq_out);

  // R8: parent line follows the unmasked pending set one edge later
  a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(status_q & ~mask_q)));
endmodule

bind gpio_lvl_irq_port gpio_lvl_irq_chk #(.W(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wdata(bus_wdata),
  .status_q(status_q), .mask_q(mask_q), .ev_hit(ev_hit), .pin_oe(pin_oe),
  .ev_ack_we(ev_ack_we), .ev_dir_we(ev_dir_we), .irq_out(irq_out)
);

// File: tb/gpio_lvl_irq_port_tb.sv
`timescale 1ns/1ps
module gpio_lvl_irq_port_tb;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]   bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, pin_in = '0;
  logic [N-1:0] bus_rdata, pin_out, pin_oe;
  logic         irq_out;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gpio_lvl_irq_port #(.NPINS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  // behavioural reference
  bit [N-1:0] m_s1, m_s2, m_dir, m_dout, m_pol, m_stat, m_mask, t_stat;
  bit         m_irq;

  function automatic bit [N-1:0] exp_read(input bit [4:0] a);
    bit [N-1:0] v;
    v = '0;
    if (a[4] == 1'b0) begin
      if (a[3:0] == 4'd0)  v = m_dir;
      if (a[3:0] == 4'd4)  for (int k = 0; k < N; k++) v[k] = m_dir[k] ? m_dout[k] : m_s2[k];
      if (a[3:0] == 4'd8)  v = m_pol;
      if (a[3:0] == 4'd12) v = m_stat;
    end else begin
      if (a[3:0] == 4'd0)  v = m_stat;
      if (a[3:0] == 4'd8)  v = m_mask;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s1 <= '0; m_s2 <= '0; m_dir <= '0; m_dout <= '0; m_pol <= '0;
      m_stat <= '0; m_mask <= '1; m_irq <= 1'b0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (bus_wr && bus_addr == 5'h0C) t_stat[k] = m_stat[k] && bus_wdata[k];
        else t_stat[k] = m_stat[k] || (m_s2[k] == m_pol[k]);
      end
      m_irq  <= (m_stat & ~m_mask) != 0;
      m_stat <= t_stat;
      m_s2   <= m_s1;
      m_s1   <= pin_in;
      if (bus_wr) begin
        case (bus_addr)
          5'h00: m_dir  <= bus_wdata;
          5'h04: m_dout <= bus_wdata;
          5'h08: m_pol  <= bus_wdata;
          5'h18: m_mask <= bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input bit [N-1:0] act, input bit [N-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // outputs compared every cycle, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(pin_oe,  m_dir,  "R2 pin_oe");
      chk(pin_out, m_dout, "R2 pin_out");
      chk({{(N-1){1'b0}}, irq_out}, {{(N-1){1'b0}}, m_irq}, "R8 irq_out");
    end
  end

  task automatic do_wr(input bit [4:0] a, input bit [N-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_rd = 1'b0; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic do_rd(input bit [4:0] a, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(bus_rdata, exp_read(a), tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_pins(input bit [N-1:0] v);
    @(negedge clk);
    pin_in = v;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1;
      fails++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R1 reset values
    do_rd(5'h18, "R1 mask reset");
    do_rd(5'h00, "R1 dir reset");
    do_rd(5'h08, "R1 pol reset");
    chk(bus_rdata, '0, "R9 rdata idle");
    // R2 direction and data
    do_wr(5'h00, 32'h0000_FFFF);
    do_wr(5'h04, 32'hA5A5_5A5A);
    do_rd(5'h00, "R2 dir readback");
    // R3 synchroniser and mixed read-back
    set_pins(32'h1234_0000);
    do_rd(5'h04, "R3 data one edge after pin change");
    do_rd(5'h04, "R3 data after sync");
    // R4/R5 level high polarity
    do_wr(5'h08, 32'hFFFF_FFFF);
    set_pins(32'h0);
    repeat (3) @(posedge clk);
    do_wr(5'h0C, 32'h0);
    do_rd(5'h0C, "R5 status cleared");
    set_pins(32'h0000_0020);
    repeat (3) @(posedge clk);
    do_rd(5'h0C, "R4 high level sets bit 5");
    do_rd(5'h10, "R6 pending equals status");
    do_wr(5'h10, 32'h0);
    do_rd(5'h10, "R6 pending write ignored");
    // R7/R8 unmask pin 5
    do_wr(5'h18, ~32'h0000_0020);
    do_rd(5'h18, "R7 mask readback");
    repeat (2) @(posedge clk);
    chk({31'b0, irq_out}, 32'd1, "R8 irq asserted");
    do_wr(5'h0C, ~32'h0000_0020);
    do_rd(5'h0C, "R5 re-set while level holds");
    set_pins(32'h0);
    repeat (3) @(posedge clk);
    do_wr(5'h0C, ~32'h0000_0020);
    do_rd(5'h0C, "R5 cleared after level drops");
    repeat (2) @(posedge clk);
    chk({31'b0, irq_out}, 32'd0, "R8 irq released");
    // R4 low polarity on pin 9
    do_wr(5'h08, ~32'h0000_0200);
    do_wr(5'h0C, 32'h0);
    repeat (2) @(posedge clk);
    do_rd(5'h0C, "R4 low level sets bit 9");
    // R9 unmapped offsets
    do_wr(5'h1C, 32'h0);
    do_wr(5'h14, 32'h0);
    do_wr(5'h02, 32'hFFFF_FFFF);
    do_rd(5'h18, "R9 mask unchanged");
    do_rd(5'h1C, "R9 unmapped reads zero");
    do_rd(5'h14, "R9 unmapped reads zero");
    do_rd(5'h06, "R9 unaligned reads zero");
    do_rd(5'h00, "R9 dir unchanged");
    // mixed random traffic
    for (int it = 0; it < 600; it++) begin
      int op;
      bit [4:0] a;
      op = $urandom_range(0, 3);
      a = 5'($urandom_range(0, 31));
      if ($urandom_range(0, 3) != 0) a[1:0] = 2'b00;
      case (op)
        0: do_wr(a, $urandom());
        1: do_rd(a, "R6 R9 random read");
        2: set_pins($urandom());
        default: @(posedge clk);
      endcase
    end
    repeat (4) @(posedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      summary();
      $finish;
    end
  end
endmodule